// File: doc/BRIEF.md
# Level Interrupt Aggregator with Dual CPU Outputs

This block gathers up to thirty-one level-sensitive interrupt sources and presents them to a processor on two level interrupt lines. Every source input first passes a two-flop synchronizer. After that, a per-source enable mask, a per-source routing bit and one global gate bit decide whether the source shows up as pending on CPU line 0 or on CPU line 1. Software reaches the block through a plain register port: a byte address, a write strobe, write data and combinational read data. A read returns data in the cycle its address is presented. A write takes effect at the next clock edge. The port has no back-pressure, because every access completes in one cycle.

The enable mask has no direct write path. Software changes it only through two strobe registers. A 1 written to the set register enables the matching bits. A 1 written to the clear register disables them. Zero bits leave the mask as it is. Mask bit 31 is not a source enable: it gates the whole block. The routing register is a normal read/write register. Pending bits are never latched. A pending bit follows its synchronized input, so nothing needs to be acknowledged. Software services a line by reading its status register and taking the lowest set bit. A CPU line is high exactly when its status word is nonzero.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, the mask (read at 0x34 or 0x38) and the routing register (read at 0x20) are zero, and both CPU lines are low.
- R2: A write to offset 0x34 ORs the write data into the mask. Bits written as 0 keep their value.
- R3: A write to offset 0x38 clears every mask bit written as 1. Bits written as 0 keep their value. Writing all ones clears the whole mask, gate bit 31 included.
- R4: While mask bit 31 is 0, both status registers (0x00 and 0x04) read zero and both CPU lines are low, whatever the inputs are.
- R5: While mask bit 31 is 1, the status at 0x00 equals raw AND mask AND NOT routing over bits 0 to 30, and the status at 0x04 equals raw AND mask AND routing over the same bits. Status bit 31 always reads 0. The routing register at 0x20 reads back the last value written to it.
- R6: Offset 0x30 returns each input delayed by two clock edges (two-flop synchronizer), whatever the mask holds.
- R7: Pending bits are level-sensitive. A status bit drops two edges after its input goes low, without any acknowledge.
- R8: CPU line N is high in exactly the cycles in which status register N reads nonzero, so a line is never high while its status is zero.
- R9: Reading an unmapped offset returns zero. A misaligned address (low two bits nonzero) also counts as unmapped. Writes to unmapped offsets, to the two status registers and to the raw register change neither the mask nor the routing register.
- R10: Reads of offset 0x34 and of offset 0x38 both return the current mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 6 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe; the write takes effect at the next rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_src | input | 32 | Level interrupt inputs, asynchronous; bit 31 is never pending |
| cpu_irq0 | output | 1 | Level interrupt line for sources routed with a 0 bit |
| cpu_irq1 | output | 1 | Level interrupt line for sources routed with a 1 bit |

## Verification
The assertions assume at most one register write per cycle. They also assume the address and write strobe are stable around the clock edge. The synchronizer check assumes the inputs are sampled values and carry no X after reset. The stimulus drives the address, strobe, data and source inputs only on falling edges and deasserts the strobe after one cycle. It then holds the inputs still for at least two edges before comparing any status read. Random source patterns, mask and routing writes, and writes to random offsets (including unmapped and misaligned ones) are mixed with directed clear-all, gate-off and level-drop cases.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 6;
  localparam int GATE_BIT = REG_W - 1;

  localparam logic [ADDR_W-1:0] OFS_STAT0 = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT1 = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 6'h34;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 6'h38;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/lvl_irq_cfg_regs.sv
module lvl_irq_cfg_regs
  import lvl_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      mask,
  output logic [W-1:0]      route
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask  <= '0;
      route <= '0;
    end else if (wr) begin
      unique case (addr)
        OFS_ENSET: mask  <= mask | wdata;
        OFS_ENCLR: mask  <= mask & ~wdata;
        OFS_ROUTE: route <= wdata;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/lvl_irq_route.sv
module lvl_irq_route #(
  parameter int W = 32
) (
  input  logic         [W-1:0] raw,
  input  logic         [W-1:0] mask,
  input  logic         [W-1:0] route,
  output logic [1:0]   [W-1:0] status,
  output logic [1:0]           irq
);
  localparam int          NUM_OUT  = 2;
  localparam logic [W-1:0] SRC_BITS = {1'b0, {(W-1){1'b1}}};

  logic         gate;
  logic [W-1:0] eligible;

  assign gate     = mask[W-1];
  assign eligible = raw & mask & SRC_BITS & {W{gate}};

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    if (o == 0) begin : g_zero
      assign status[o] = eligible & ~route;
    end else begin : g_one
      assign status[o] = eligible & route;
    end
    assign irq[o] = |status[o];
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int W        = REG_W,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      irq_src,
  output logic              cpu_irq0,
  output logic              cpu_irq1
);
  logic [W-1:0]       raw_q;
  logic [W-1:0]       mask_q;
  logic [W-1:0]       route_q;
  logic [1:0][W-1:0]  status;
  logic [1:0]         irq;

  lvl_irq_sync #(.W(W), .STAGES(SYNC_STG)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_src),
    .sync_out (raw_q)
  );

  lvl_irq_cfg_regs #(.W(W)) cfg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .mask  (mask_q),
    .route (route_q)
  );

  lvl_irq_route #(.W(W)) route_i (
    .raw    (raw_q),
    .mask   (mask_q),
    .route  (route_q),
    .status (status),
    .irq    (irq)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_STAT0:            reg_rdata = status[0];
      OFS_STAT1:            reg_rdata = status[1];
      OFS_ROUTE:            reg_rdata = route_q;
      OFS_RAW:              reg_rdata = raw_q;
      OFS_ENSET, OFS_ENCLR: reg_rdata = mask_q;
      default:              reg_rdata = '0;
    endcase
  end

  assign cpu_irq0 = irq[0];
  assign cpu_irq1 = irq[1];
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk
  import lvl_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [W-1:0]      reg_wdata,
  input logic [W-1:0]      reg_rdata,
  input logic [W-1:0]      irq_src,
  input logic              cpu_irq0,
  input logic              cpu_irq1,
  input logic [W-1:0]      mask,
  input logic [W-1:0]      raw
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  logic mask_wr;
  assign mask_wr = reg_wr && (reg_addr == OFS_ENSET || reg_addr == OFS_ENCLR);

  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_ENSET) |=> ((mask & $past(reg_wdata)) == $past(reg_wdata)));

  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_ENCLR) |=> ((mask & $past(reg_wdata)) == '0));

  a_r4_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[W-1] |-> (!cpu_irq0 && !cpu_irq1));

  a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (raw == $past(irq_src, 2)));

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_STAT0) |-> (cpu_irq0 == (reg_rdata != '0)));

  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_src   (irq_src),
  .cpu_irq0  (cpu_irq0),
  .cpu_irq1  (cpu_irq1),
  .mask      (mask_q),
  .raw       (raw_q)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] irq_src = '0;
  logic        cpu_irq0, cpu_irq1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] m_mask = '0;
  logic [31:0] m_route = '0;

  always #2 clk = ~clk;

  lvl_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_src(irq_src),
    .cpu_irq0(cpu_irq0), .cpu_irq1(cpu_irq1)
  );

  function automatic logic [31:0] exp_stat(input int o);
    logic [31:0] e;
    e = irq_src & m_mask & 32'h7fff_ffff;
    if (!m_mask[31]) e = '0;
    return (o == 0) ? (e & ~m_route) : (e & m_route);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      6'h20: m_route = d;
      6'h34: m_mask = m_mask | d;
      6'h38: m_mask = m_mask & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle(input logic [31:0] s);
    @(negedge clk);
    irq_src = s;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d, e0, e1;
    e0 = exp_stat(0); e1 = exp_stat(1);
    rd(6'h30, d); check({tag, " R6 raw"}, d, irq_src);
    rd(6'h34, d); check({tag, " R2 R10 mask@34"}, d, m_mask);
    rd(6'h38, d); check({tag, " R3 R10 mask@38"}, d, m_mask);
    rd(6'h20, d); check({tag, " R5 route"}, d, m_route);
    rd(6'h00, d); check({tag, " R5 stat0"}, d, e0);
    check({tag, " R8 irq0"}, {31'd0, cpu_irq0}, {31'd0, e0 != 0});
    rd(6'h04, d); check({tag, " R5 stat1"}, d, e1);
    check({tag, " R8 irq1"}, {31'd0, cpu_irq1}, {31'd0, e1 != 0});
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(6'h34, d); check("R1 mask", d, 32'h0);
    rd(6'h20, d); check("R1 route", d, 32'h0);
    check("R1 irq lines", {30'd0, cpu_irq1, cpu_irq0}, 32'h0);

    // R4 gate off with sources active
    wr(6'h34, 32'h0000_00ff);
    settle(32'hffff_ffff);
    rd(6'h00, d); check("R4 stat0 gated", d, 32'h0);
    rd(6'h04, d); check("R4 stat1 gated", d, 32'h0);
    check("R4 irq gated", {30'd0, cpu_irq1, cpu_irq0}, 32'h0);

    // R5 routing with gate on
    wr(6'h20, 32'h0000_00f0);
    wr(6'h34, 32'h8000_0000);
    check_all("dir-route");

    // R7 level drop, no acknowledge
    settle(32'h0000_0000);
    rd(6'h00, d); check("R7 stat0 drop", d, 32'h0);
    check("R7 irq0 drop", {31'd0, cpu_irq0}, 32'h0);

    // R3 clear all including gate
    settle(32'h8000_0101);
    wr(6'h38, 32'hffff_ffff);
    rd(6'h34, d); check("R3 clear all", d, 32'h0);
    check("R3 irq after clear", {30'd0, cpu_irq1, cpu_irq0}, 32'h0);

    // R9 writes to unmapped, misaligned, status and raw offsets ignored
    wr(6'h34, 32'h8000_0003);
    wr(6'h20, 32'h0000_0002);
    wr(6'h10, 32'hffff_ffff);
    wr(6'h21, 32'hffff_ffff);
    wr(6'h35, 32'hffff_ffff);
    wr(6'h00, 32'hffff_ffff);
    wr(6'h04, 32'hffff_ffff);
    wr(6'h30, 32'hffff_ffff);
    rd(6'h10, d); check("R9 unmapped read", d, 32'h0);
    rd(6'h36, d); check("R9 misaligned read", d, 32'h0);
    check_all("dir-ignore");

    // random phase
    for (int i = 0; i < 300; i++) begin
      logic [5:0]  a;
      logic [31:0] v;
      int sel;
      sel = $urandom_range(0, 9);
      v = $urandom;
      if ($urandom_range(0, 1) == 1) v = v & $urandom;
      case (sel)
        0, 1, 2: a = 6'h34;
        3, 4:    a = 6'h38;
        5, 6:    a = 6'h20;
        default: a = 6'($urandom_range(0, 63));
      endcase
      wr(a, v);
      settle($urandom & $urandom);
      check_all("rnd");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule